// File: doc/BRIEF.md
# LED Status Panel

This peripheral sits on an APB bus and drives eight active-high LEDs. Two sources can light them. In the normal mode, software writes a byte-wide pattern register, and each 1 bit lights the matching LED. In the override mode, the LEDs instead show eight processor status strobes, with a fixed bit assignment.

The status strobes are often only one clock long. Each one therefore passes through its own retriggerable stretcher, which holds the LED lit for a parameterised number of cycles. The stretchers run in both modes, so a flash that starts just before a mode change is still shown after it. The same register window also gives read-only access to eight DIP switches. These are brought into the clock domain by a two-flop synchroniser.

The bus side is a plain zero-wait-state APB slave. The bus address is compared as a whole byte offset. A read from an offset with no register returns zero, and a write to such an offset does nothing.

Top module: `led_status_panel`

## Requirements
- R1: After reset the LEDs are all dark. The pattern register (offset 0x0C) and the mode bit (offset 0x14) both read back as zero.
- R2: A write to offset 0x0C stores pwdata[7:0] in the pattern register. A read from 0x0C returns the stored byte in bits 7:0, with zero in bits 31:8.
- R3: While the mode bit is 0, led_o equals the pattern register.
- R4: Offset 0x14 bit 0 is the mode bit, and it reads back in bit 0. While it is 1, led_o[k] shows the stretched form of status_i[k]. The bit assignment is fixed: 7 sleeping, 6 deep sleep, 5 halted, 4 lockup, 3 system-reset request, 2 event sent, 1 wakeup, 0 debug restarted.
- R5: A status bit sampled high at a clock edge makes its stretched output high for exactly STRETCH_CYCLES cycles, starting right after that edge, if no new pulse arrives.
- R6: A new pulse on a status bit while it is being stretched restarts that bit's full STRETCH_CYCLES window.
- R7: The stretchers count in both modes. A pulse taken while the mode bit is 0 appears, with its remaining time, once override mode is selected.
- R8: A read from offset 0x08 returns sw_i in bits 7:0. The value is delayed by two synchroniser flops. Writes to 0x08 have no effect.
- R9: Writes to offsets with no register, and to reserved bits (0x0C bits 31:8, 0x14 bits 31:1), are ignored. Such bits and offsets read as zero.
- R10: A write to the mode bit changes the LED source in the cycle right after the APB access phase completes, and not before.
- R11: pready is always high, so every transfer finishes in its first access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Synchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when 1, read when 0 |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data, zero when not selected for a read |
| pready | output | 1 | Transfer ready, tied high |
| sw_i | input | 8 | DIP switch levels, asynchronous |
| status_i | input | 8 | Processor status strobes, bit order as in R4 |
| led_o | output | 8 | LED drive, 1 lights the LED |

## Verification
The hardest case to reach is a strobe that arrives while the pattern register drives the LEDs and is still being stretched when override mode is selected (R7). The case also covers a second strobe that lands in the middle of an active window (R6). A directed sequence pulses one status bit in normal mode and sets the mode bit a few cycles later. The bench then times the remaining flash and the retriggered window cycle by cycle. Beyond that directed sequence, a seeded random phase mixes sparse strobes with writes and reads at mapped and unmapped offsets. Throughout the run, a bench-side model of the pattern, the mode bit and the per-bit counters checks led_o after every clock edge.

// File: rtl/led_panel_pkg.sv
// Package: register offsets and status bit positions shared by the LED panel
// and its checker. Assumes a byte-addressed APB window with whole-offset decode.
package led_panel_pkg;

    localparam logic [7:0] OFS_SWITCH  = 8'h08;
    localparam logic [7:0] OFS_PATTERN = 8'h0C;
    localparam logic [7:0] OFS_MODE    = 8'h14;

    localparam int LED_COUNT = 8;

    // Fixed bit positions of the status strobes on status_i / led_o.
    typedef enum int {
        ST_DBG_RESTART = 0,
        ST_WAKEUP      = 1,
        ST_EVENT_TX    = 2,
        ST_RESET_REQ   = 3,
        ST_LOCKUP      = 4,
        ST_HALTED      = 5,
        ST_DEEP_SLEEP  = 6,
        ST_SLEEPING    = 7
    } status_bit_e;

    typedef enum logic {
        SRC_PATTERN  = 1'b0,
        SRC_OVERRIDE = 1'b1
    } led_src_e;

endpackage

// File: rtl/led_sw_sync.sv
// Module: multi-flop synchroniser for a bus of slow, independent level inputs.
// Assumes every bit is a quasi-static level (switch), so per-bit skew is harmless.
module led_sw_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the level one flop further along the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else begin
                    chain[s] <= (s == 0) ? async_i : chain[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/led_stretch.sv
// Module: retriggerable pulse stretcher for one status strobe.
// A high input at a clock edge reloads the counter to CYCLES; the output is high
// while the counter is non-zero. Assumes CYCLES >= 1.
module led_stretch #(
    parameter int CYCLES = 1 << 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic lit_o
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] remain_q;

    // Reload on a strobe, otherwise count the window down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (pulse_i) begin
            remain_q <= LOAD;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign lit_o = (remain_q != '0);

endmodule

// File: rtl/led_apb_regs.sv
// Module: APB register window holding the LED pattern and the source-select bit,
// and returning the synchronised switch levels. Zero wait states, whole-offset
// decode, unmapped offsets and reserved bits read zero and ignore writes.
module led_apb_regs
    import led_panel_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int LEDS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    input  logic [LEDS-1:0]   sw_sync_i,
    output logic [LEDS-1:0]   pattern_o,
    output led_src_e          src_o
);

    localparam logic [ADDR_W-1:0] A_SW   = ADDR_W'(OFS_SWITCH);
    localparam logic [ADDR_W-1:0] A_PAT  = ADDR_W'(OFS_PATTERN);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);

    logic            wr_en;
    logic [LEDS-1:0] pattern_q;
    led_src_e        src_q;
    logic            unused_wdata;

    assign wr_en        = psel && penable && pwrite;
    assign unused_wdata = ^pwdata[DATA_W-1:LEDS];

    // Capture writes to the pattern byte and the mode bit; all else is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pattern_q <= '0;
            src_q     <= SRC_PATTERN;
        end else if (wr_en) begin
            if (paddr == A_PAT) begin
                pattern_q <= pwdata[LEDS-1:0];
            end
            if (paddr == A_MODE) begin
                src_q <= led_src_e'(pwdata[0]);
            end
        end
    end

    // Return read data for mapped offsets, zero everywhere else.
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            if (paddr == A_SW) begin
                prdata[LEDS-1:0] = sw_sync_i;
            end else if (paddr == A_PAT) begin
                prdata[LEDS-1:0] = pattern_q;
            end else if (paddr == A_MODE) begin
                prdata[0] = src_q;
            end
        end
    end

    assign pready    = 1'b1;
    assign pattern_o = pattern_q;
    assign src_o     = src_q;

endmodule

// File: rtl/led_status_panel.sv
// Module: top of the LED panel. Combines the APB register window, the switch
// synchroniser and one stretcher per status strobe, and selects the LED source.
// Assumes a single clock domain for the bus and status strobes.
module led_status_panel
    import led_panel_pkg::*;
#(
    parameter int ADDR_W         = 12,
    parameter int DATA_W         = 32,
    parameter int STRETCH_CYCLES = 1 << 20,
    parameter int SYNC_STAGES    = 2
) (
    input  logic                 pclk,
    input  logic                 presetn,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    input  logic [DATA_W-1:0]    pwdata,
    output logic [DATA_W-1:0]    prdata,
    output logic                 pready,
    input  logic [LED_COUNT-1:0] sw_i,
    input  logic [LED_COUNT-1:0] status_i,
    output logic [LED_COUNT-1:0] led_o
);

    logic [LED_COUNT-1:0] sw_sync;
    logic [LED_COUNT-1:0] pattern;
    logic [LED_COUNT-1:0] stretched;
    led_src_e             mode_q;

    led_sw_sync #(
        .WIDTH  (LED_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (pclk),
        .rst_n   (presetn),
        .async_i (sw_i),
        .sync_o  (sw_sync)
    );

    led_apb_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LEDS   (LED_COUNT)
    ) u_regs (
        .clk       (pclk),
        .rst_n     (presetn),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .pready    (pready),
        .sw_sync_i (sw_sync),
        .pattern_o (pattern),
        .src_o     (mode_q)
    );

    generate
        for (genvar k = 0; k < LED_COUNT; k++) begin : g_stretch
            led_stretch #(
                .CYCLES (STRETCH_CYCLES)
            ) u_st (
                .clk     (pclk),
                .rst_n   (presetn),
                .pulse_i (status_i[k]),
                .lit_o   (stretched[k])
            );
        end
    endgenerate

    // Pick the LED source named by the mode bit.
    always_comb begin
        led_o = (mode_q == SRC_OVERRIDE) ? stretched : pattern;
    end

endmodule

// File: rtl/led_status_panel_chk.sv
// Module: assertion checker bound into led_status_panel. Observes the bus, the
// status strobes, the stretcher outputs and the LED pins.
module led_status_panel_chk
    import led_panel_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic                 pclk,
    input logic                 presetn,
    input logic                 psel,
    input logic                 penable,
    input logic                 pwrite,
    input logic [ADDR_W-1:0]    paddr,
    input logic [DATA_W-1:0]    pwdata,
    input logic [DATA_W-1:0]    prdata,
    input logic [LED_COUNT-1:0] sw_i,
    input logic [LED_COUNT-1:0] status_i,
    input logic [LED_COUNT-1:0] stretched,
    input logic                 mode_q,
    input logic [LED_COUNT-1:0] led_o
);

    logic [1:0] warm_q;

    // Count the first cycles after reset so two-deep history is valid.
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            warm_q <= '0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R1: a cycle in reset leaves the LEDs dark.
    p_dark_after_reset_r1: assert property (@(posedge pclk)
        !presetn |=> (led_o == '0));

    // R3: a pattern write in normal mode appears on the LEDs next cycle.
    p_pattern_shown_r3: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && pwrite && paddr == ADDR_W'(OFS_PATTERN) && !mode_q)
        |=> (led_o == $past(pwdata[LED_COUNT-1:0])));

    // R5: a sampled strobe makes its stretched output high after the edge.
    p_stretch_start_r5: assert property (@(posedge pclk) disable iff (!presetn)
        (status_i != '0) |=> ((stretched & $past(status_i)) == $past(status_i)));

    // R6: a stretched output never drops right after its strobe was sampled.
    p_no_drop_on_retrigger_r6: assert property (@(posedge pclk) disable iff (!presetn)
        1'b1 |=> ((~stretched & $past(stretched) & $past(status_i)) == '0));

    // R10: a mode write sets the source bit in the following cycle.
    p_mode_switch_r10: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && pwrite && paddr == ADDR_W'(OFS_MODE))
        |=> (mode_q == $past(pwdata[0])));

    // R9: reserved read bits stay zero.
    p_reserved_zero_r9: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !pwrite) |-> (prdata[DATA_W-1:LED_COUNT] == '0));

    // R8: switch readback lags the pins by two flops.
    p_switch_sync_r8: assert property (@(posedge pclk) disable iff (!presetn)
        (warm_q == 2'd3 && psel && !pwrite && paddr == ADDR_W'(OFS_SWITCH))
        |-> (prdata[LED_COUNT-1:0] == $past(sw_i, 2)));

endmodule

bind led_status_panel led_status_panel_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .pclk      (pclk),
    .presetn   (presetn),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .prdata    (prdata),
    .sw_i      (sw_i),
    .status_i  (status_i),
    .stretched (stretched),
    .mode_q    (mode_q),
    .led_o     (led_o)
);

// File: tb/led_status_panel_tb.sv
module led_status_panel_tb;

    localparam int S  = 16;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          pclk = 1'b0;
    logic          presetn = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0;
    logic [DW-1:0] prdata;
    logic          pready;
    logic [7:0]    sw_i = 8'h00;
    logic [7:0]    status_i = 8'h00;
    logic [7:0]    led_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit mon_en = 1'b0;

    // Bench model of the requirements.
    logic [7:0] m_pat = '0;
    logic       m_mode = 1'b0;
    int         m_cnt [8];

    always #2.5 pclk = ~pclk;

    led_status_panel #(
        .ADDR_W (AW),
        .DATA_W (DW),
        .STRETCH_CYCLES (S)
    ) u_dut (
        .pclk (pclk), .presetn (presetn), .psel (psel), .penable (penable),
        .pwrite (pwrite), .paddr (paddr), .pwdata (pwdata), .prdata (prdata),
        .pready (pready), .sw_i (sw_i), .status_i (status_i), .led_o (led_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_stretched();
        logic [7:0] v;
        for (int k = 0; k < 8; k++) v[k] = (m_cnt[k] != 0);
        return v;
    endfunction

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        case (a)
            12'h008: return {24'h0, sw_i};
            12'h00C: return {24'h0, m_pat};
            12'h014: return {31'h0, m_mode};
            default: return 32'h0;
        endcase
    endfunction

    // Model update at each clock edge from the bench's own stimulus.
    always @(posedge pclk) begin
        if (!presetn) begin
            m_pat = '0; m_mode = 1'b0;
            for (int k = 0; k < 8; k++) m_cnt[k] = 0;
        end else begin
            for (int k = 0; k < 8; k++) begin
                if (status_i[k]) m_cnt[k] = S;
                else if (m_cnt[k] > 0) m_cnt[k] = m_cnt[k] - 1;
            end
            if (psel && penable && pwrite) begin
                if (paddr == 12'h00C) m_pat = pwdata[7:0];
                if (paddr == 12'h014) m_mode = pwdata[0];
            end
        end
    end

    // Continuous LED check, R3 in normal mode and R5/R7 in override.
    always @(negedge pclk) begin
        #1;
        if (mon_en) begin
            if (m_mode) check("R5 led_o vs stretch model", {24'h0, led_o}, {24'h0, model_stretched()});
            else        check("R3 led_o vs pattern", {24'h0, led_o}, {24'h0, m_pat});
        end
    end

    task automatic apb_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge pclk); penable = 1;
        @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge pclk); penable = 1; #1; d = prdata;
        check("R11 pready", {31'h0, pready}, 32'h1);
        @(negedge pclk); psel = 0; penable = 0;
    endtask

    task automatic pulse(input int k);
        @(negedge pclk); status_i = 8'(1 << k);
        @(negedge pclk); status_i = 8'h00; #1;
    endtask

    function automatic int count_lit_init();
        return 0;
    endfunction

    task automatic count_lit(input int k, output int n);
        n = count_lit_init();
        while (led_o[k] && n < 100) begin
            n++;
            @(negedge pclk); #1;
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge pclk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int n;
        void'($urandom(32'h5EED1234));
        repeat (4) @(posedge pclk);
        @(negedge pclk); presetn = 1'b1;
        @(negedge pclk); #1;

        // R1 reset state
        check("R1 leds dark", {24'h0, led_o}, 32'h0);
        apb_read(12'h00C, rd); check("R1 pattern reset", rd, 32'h0);
        apb_read(12'h014, rd); check("R1 mode reset", rd, 32'h0);
        mon_en = 1'b1;

        // R2 / R3 pattern write with reserved bits set
        apb_write(12'h00C, 32'hFFFF_FFA5);
        apb_read(12'h00C, rd); check("R2 pattern readback", rd, 32'h0000_00A5);
        check("R3 leds follow pattern", {24'h0, led_o}, 32'hA5);

        // R8 switch sync depth and read-only
        @(negedge pclk); sw_i = 8'h3C;
        psel = 1; penable = 0; pwrite = 0; paddr = 12'h008;
        @(negedge pclk); penable = 1; #1;
        check("R8 switch not yet visible after one edge", prdata, 32'h0);
        @(negedge pclk); psel = 0; penable = 0;
        apb_read(12'h008, rd); check("R8 switch readback", rd, 32'h3C);
        apb_write(12'h008, 32'hFF);
        apb_read(12'h008, rd); check("R8 switch write ignored", rd, 32'h3C);

        // R9 unmapped and reserved writes ignored
        apb_write(12'h010, 32'hFFFF_FFFF);
        apb_write(12'h000, 32'h0000_0011);
        apb_read(12'h010, rd); check("R9 unmapped reads zero", rd, 32'h0);
        apb_read(12'h00C, rd); check("R9 pattern untouched", rd, 32'hA5);
        apb_write(12'h014, 32'hFFFF_FFFE);
        apb_read(12'h014, rd); check("R9 mode reserved bits ignored", rd, 32'h0);
        check("R9 leds still pattern", {24'h0, led_o}, 32'hA5);

        // R7 strobe in normal mode, then R10 switch timing
        pulse(3);
        check("R7 normal mode hides strobe", {24'h0, led_o}, 32'hA5);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = 12'h014; pwdata = 32'h1;
        @(negedge pclk); penable = 1; #1;
        check("R10 no change before completion", {24'h0, led_o}, 32'hA5);
        @(negedge pclk); psel = 0; penable = 0; pwrite = 0; #1;
        check("R10 R7 override shows running stretch", {24'h0, led_o}, 32'h08);
        count_lit(3, n);
        check("R7 remaining window", n, S - 3);

        // R4 bit order and R5 exact length
        for (int k = 0; k < 8; k++) begin
            pulse(k);
            check("R4 bit position", {24'h0, led_o}, 32'(1 << k));
            count_lit(k, n);
            check("R5 stretch length", n, S);
        end

        // R6 retrigger restarts window
        pulse(ST_IDX_HALT);
        repeat (9) @(negedge pclk);
        pulse(ST_IDX_HALT);
        count_lit(ST_IDX_HALT, n);
        check("R6 retrigger full window", n, S);

        // Random phase
        for (int i = 0; i < 1500; i++) begin
            int sel;
            logic [AW-1:0] a;
            sel = int'($urandom_range(0, 9));
            case ($urandom_range(0, 3))
                0: a = 12'h008; 1: a = 12'h00C; 2: a = 12'h014; default: a = 12'h010;
            endcase
            if (sel < 6) begin
                @(negedge pclk);
                status_i = 8'h00;
                for (int k = 0; k < 8; k++) if ($urandom_range(0, 15) == 0) status_i[k] = 1'b1;
            end else if (sel < 8) begin
                @(negedge pclk); status_i = 8'h00;
                apb_write(a, $urandom());
            end else begin
                @(negedge pclk); status_i = 8'h00;
                apb_read(a, rd);
                check("R2 R8 R9 random read", rd, model_read(a));
            end
        end
        @(negedge pclk); status_i = 8'h00;
        repeat (S + 4) @(negedge pclk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    localparam int ST_IDX_HALT = 5;

endmodule